// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block moves one processor core between four power states: RUN, HALT, extended HALT (XHALT) and STOP-GRANT (STOPG). In each state it drives a clock-gate enable vector, with one bit for each internal section of the core. Each state gates a different set of sections. XHALT gates the most, because it is the deepest state. When a halt instruction retires while the core is in RUN, the controller picks XHALT only if firmware has set the deep-halt enable and the bus-to-core ratio is not already at its floor. Otherwise it picks plain HALT.

In XHALT the controller holds a ratio-drop request towards the clock generator. The stop-clock input is active low and takes priority over every other event. On entry to STOPG the controller issues a one-cycle request for a Stop Grant special bus cycle. When stop-clock is released, the core goes back to the state it was in before STOPG. The transitions are:
- RUN->HALT and RUN->XHALT on a halt event.
- HALT->RUN and XHALT->RUN on a wake event.
- RUN, HALT or XHALT -> STOPG on stop-clock.
- STOPG -> the saved state on release.

Top module: `lpstate_ctrl`

## Requirements
- R1: After reset the state is RUN (`pstate` = 2'b00), `gate_en` is all zeros, and both `ratio_drop_req` and `sbc_req` are low.
- R2: A halt event in RUN, with `deep_halt_en` = 1 and `ratio_at_min` = 0, moves the core to XHALT (`pstate` = 2'b10) on the next clock, with `gate_en` = 3'b111.
- R3: A halt event in RUN with `deep_halt_en` = 0 or `ratio_at_min` = 1 moves the core to HALT (`pstate` = 2'b01) on the next clock, with `gate_en` = 3'b001.
- R4: A wake event in HALT or XHALT returns the core to RUN (`pstate` = 2'b00, `gate_en` = 3'b000) on the next clock.
- R5: `stopclk_n` low in RUN, HALT or XHALT moves the core to STOPG (`pstate` = 2'b11, `gate_en` = 3'b011) on the next clock. This wins over a halt or wake event in the same cycle.
- R6: `sbc_req` is high for exactly the first cycle of each STOPG stay, and is low at all other times.
- R7: `ratio_drop_req` is high exactly while the state is XHALT. It is asserted on entry and dropped when the core leaves XHALT.
- R8: `stopclk_n` high in STOPG returns the core, on the next clock, to the state held just before STOPG was entered.
- R9: A halt or wake event has no effect in STOPG. A wake event has no effect in RUN. A halt event has no effect in HALT or XHALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_evt | input | 1 | A halt instruction has retired (one cycle) |
| wake_evt | input | 1 | Interrupt or other wake event |
| stopclk_n | input | 1 | Stop-clock request, active low |
| deep_halt_en | input | 1 | Firmware enable for extended HALT |
| ratio_at_min | input | 1 | Bus-to-core ratio is already at its minimum |
| pstate | output | 2 | Current state: RUN 00, HALT 01, XHALT 10, STOPG 11 |
| gate_en | output | GATE_W | Clock-gate enables, one bit for each section |
| ratio_drop_req | output | 1 | Request to lower the bus-to-core ratio |
| sbc_req | output | 1 | One-cycle Stop Grant special bus cycle request |

## Verification
The assertions assume that every input is synchronous to `clk` and settled before the rising edge. They also assume that `deep_halt_en` and `ratio_at_min` describe the cycle in which the halt event is sampled. The bench drives all inputs on the falling edge and changes the firmware and ratio flags only in the same cycle as the event they qualify. It reads the outputs half a cycle after the edge that updates the state.

// File: rtl/lpstate_pkg.sv
package lpstate_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'b00,
        PS_HALT  = 2'b01,
        PS_XHALT = 2'b10,
        PS_STOPG = 2'b11
    } pstate_e;
endpackage

// File: rtl/lpstate_fsm.sv
module lpstate_fsm
    import lpstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt_evt,
    input  logic    wake_evt,
    input  logic    stop_req,
    input  logic    deep_ok,
    output pstate_e state_q
);
    pstate_e state_d;
    pstate_e saved_q;
    pstate_e saved_d;

    // next-state selection; stop request outranks every other event
    always_comb begin
        state_d = state_q;
        saved_d = saved_q;
        unique case (state_q)
            PS_RUN: begin
                if (stop_req) begin
                    state_d = PS_STOPG;
                    saved_d = PS_RUN;
                end else if (halt_evt) begin
                    state_d = deep_ok ? PS_XHALT : PS_HALT;
                end
            end
            PS_HALT, PS_XHALT: begin
                if (stop_req) begin
                    state_d = PS_STOPG;
                    saved_d = state_q;
                end else if (wake_evt) begin
                    state_d = PS_RUN;
                end
            end
            PS_STOPG: begin
                if (!stop_req) state_d = saved_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            saved_q <= PS_RUN;
        end else begin
            state_q <= state_d;
            saved_q <= saved_d;
        end
    end

    p_stop_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && state_q != PS_STOPG) |=> state_q == PS_STOPG);

    p_no_stopg_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && state_q == PS_STOPG) |=> state_q == PS_STOPG);

    p_no_halt_in_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HALT && !stop_req && !wake_evt) |=> state_q == PS_HALT);
endmodule

// File: rtl/lpstate_outdec.sv
module lpstate_outdec
    import lpstate_pkg::*;
#(
    parameter int unsigned GATE_W     = 3,
    parameter logic [GATE_W-1:0] HALT_MASK  = 3'b001,
    parameter logic [GATE_W-1:0] STOPG_MASK = 3'b011,
    parameter logic [GATE_W-1:0] XHALT_MASK = 3'b111
) (
    input  pstate_e           state,
    output logic [GATE_W-1:0] gate_en,
    output logic              ratio_drop
);
    always_comb begin
        gate_en    = '0;
        ratio_drop = 1'b0;
        unique case (state)
            PS_RUN:   gate_en = '0;
            PS_HALT:  gate_en = HALT_MASK;
            PS_XHALT: begin
                gate_en    = XHALT_MASK;
                ratio_drop = 1'b1;
            end
            PS_STOPG: gate_en = STOPG_MASK;
        endcase
    end
endmodule

// File: rtl/lpstate_entry_pulse.sv
module lpstate_entry_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign pulse = level && !level_q;

    p_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/lpstate_ctrl.sv
module lpstate_ctrl
    import lpstate_pkg::*;
#(
    parameter int unsigned GATE_W     = 3,
    parameter logic [GATE_W-1:0] HALT_MASK  = 3'b001,
    parameter logic [GATE_W-1:0] STOPG_MASK = 3'b011,
    parameter logic [GATE_W-1:0] XHALT_MASK = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_evt,
    input  logic              wake_evt,
    input  logic              stopclk_n,
    input  logic              deep_halt_en,
    input  logic              ratio_at_min,
    output logic [1:0]        pstate,
    output logic [GATE_W-1:0] gate_en,
    output logic              ratio_drop_req,
    output logic              sbc_req
);
    pstate_e state;
    logic    stop_req;
    logic    deep_ok;

    assign stop_req = !stopclk_n;
    assign deep_ok  = deep_halt_en && !ratio_at_min;

    lpstate_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_evt (halt_evt),
        .wake_evt (wake_evt),
        .stop_req (stop_req),
        .deep_ok  (deep_ok),
        .state_q  (state)
    );

    lpstate_outdec #(
        .GATE_W     (GATE_W),
        .HALT_MASK  (HALT_MASK),
        .STOPG_MASK (STOPG_MASK),
        .XHALT_MASK (XHALT_MASK)
    ) u_dec (
        .state      (state),
        .gate_en    (gate_en),
        .ratio_drop (ratio_drop_req)
    );

    lpstate_entry_pulse u_sbc (
        .clk   (clk),
        .rst_n (rst_n),
        .level (state == PS_STOPG),
        .pulse (sbc_req)
    );

    assign pstate = state;

    p_deep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && halt_evt && stopclk_n && deep_halt_en && !ratio_at_min)
        |=> (state == PS_XHALT && ratio_drop_req));

    p_shallow_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && halt_evt && stopclk_n && (!deep_halt_en || ratio_at_min))
        |=> state == PS_HALT);

    p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PS_HALT || state == PS_XHALT) && wake_evt && stopclk_n)
        |=> (state == PS_RUN && !ratio_drop_req));

    p_sbc_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_STOPG && !stopclk_n) |=> sbc_req);

    p_sbc_only_stopg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sbc_req |-> state == PS_STOPG);

    p_ratio_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_drop_req |-> state == PS_XHALT);

    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_STOPG && stopclk_n) |=> state != PS_STOPG);
endmodule

// File: tb/tb_lpstate_ctrl.sv
module tb_lpstate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_evt = 1'b0, wake_evt = 1'b0, stopclk_n = 1'b1;
    logic       deep_halt_en = 1'b0, ratio_at_min = 1'b0;
    logic [1:0] pstate;
    logic [2:0] gate_en;
    logic       ratio_drop_req, sbc_req;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    lpstate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_evt(halt_evt), .wake_evt(wake_evt),
        .stopclk_n(stopclk_n), .deep_halt_en(deep_halt_en),
        .ratio_at_min(ratio_at_min), .pstate(pstate), .gate_en(gate_en),
        .ratio_drop_req(ratio_drop_req), .sbc_req(sbc_req)
    );

    // {halt, wake, stopclk_n, deep_en, at_min, exp_state, exp_gate, exp_drop, exp_sbc}
    localparam int NV = 20;
    localparam logic [11:0] VEC [NV] = '{
        12'b00100_00_000_0_0, // idle RUN
        12'b10100_01_001_0_0, // R3 enable clear -> HALT
        12'b00100_01_001_0_0, // R9 stay HALT
        12'b01100_00_000_0_0, // R4 wake -> RUN
        12'b10110_10_111_1_0, // R2 R7 -> XHALT
        12'b01110_00_000_0_0, // R4 R7 wake -> RUN
        12'b10111_01_001_0_0, // R3 ratio at min -> HALT
        12'b01100_00_000_0_0, // R4
        12'b00000_11_011_0_1, // R5 R6 stop from RUN
        12'b00000_11_011_0_0, // R6 pulse gone
        12'b10000_11_011_0_0, // R9 halt ignored in STOPG
        12'b00100_00_000_0_0, // R8 back to RUN
        12'b10010_11_011_0_1, // R5 stop beats halt
        12'b00110_00_000_0_0, // R8
        12'b10110_10_111_1_0, // R2
        12'b00010_11_011_0_1, // R5 R7 stop from XHALT
        12'b01010_11_011_0_0, // R9 wake ignored in STOPG
        12'b00110_10_111_1_0, // R8 R7 back to XHALT
        12'b01110_00_000_0_0, // R4
        12'b01100_00_000_0_0  // R9 wake ignored in RUN
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic h, input logic w, input logic s,
                        input logic e, input logic m);
        halt_evt = h; wake_evt = w; stopclk_n = s;
        deep_halt_en = e; ratio_at_min = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic [1:0] st,
                             input logic [2:0] g, input logic rd, input logic sb);
        check({req, " state"}, int'(pstate), int'(st));
        check({req, " gate"}, int'(gate_en), int'(g));
        check({req, " ratio_drop"}, int'(ratio_drop_req), int'(rd));
        check({req, " sbc"}, int'(sbc_req), int'(sb));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset", 2'b00, 3'b000, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release", 2'b00, 3'b000, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
            check_all($sformatf("vec%0d R2-table", i), VEC[i][6:5], VEC[i][4:2],
                      VEC[i][1], VEC[i][0]);
        end

        // R8: stop from HALT returns to HALT; R6: second entry pulses again
        step(1, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        check_all("R6 second entry", 2'b11, 3'b011, 1'b0, 1'b1);
        step(0, 0, 1, 0, 0);
        check_all("R8 return HALT", 2'b01, 3'b001, 1'b0, 1'b0);
        // R9: halt in HALT with deep enable has no effect
        step(1, 0, 1, 1, 0);
        check_all("R9 halt in HALT", 2'b01, 3'b001, 1'b0, 1'b0);
        step(0, 0, 0, 0, 0);
        check_all("R6 third entry", 2'b11, 3'b011, 1'b0, 1'b1);
        step(0, 0, 1, 0, 0);
        step(0, 1, 1, 0, 0);
        check_all("R4 wake HALT", 2'b00, 3'b000, 1'b0, 1'b0);

        // R1: reset taken in XHALT
        step(1, 0, 1, 1, 0);
        check_all("R7 deep again", 2'b10, 3'b111, 1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        check_all("R1 reset from XHALT", 2'b00, 3'b000, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 1, 0, 0);
        check_all("R1 idle after reset", 2'b00, 3'b000, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule